// File: doc/BRIEF.md
# ADC Conversion Clock Divider

This block turns the peripheral clock into the timing enables that an ADC sequencer runs on. The clock passes through a fixed halving stage, then an optional 15-bit prescaler, then a scaler. A strap input picks one of two arrangements. In the cascaded arrangement the prescaler feeds a 10-bit scaler. In the single-stage arrangement the prescaler is bypassed and a 16-bit scaler is used. The divider values live in one 32-bit control word, which is written and read back over a plain register port.

The block has two outputs, and neither is a clock. `adc_tick` is high for exactly one peripheral-clock cycle per ADC clock period. `sample_strobe` marks the last tick of each run of twelve ticks, because a conversion takes twelve ADC clocks. A new control word, or a change on the strap, has no effect on the period in progress. The new setting is taken at the next tick, so a period is never cut short or drawn out.

Top module: `adc_sample_clkdiv`

## Requirements
- R1: After reset the control word reads 0 and `adc_tick` rises once every 2 peripheral cycles.
- R2: With `mode_single`=0 the tick period is 2·(P+1)·(S+1) cycles. P is control bits [31:17] and S is control bits [9:0].
- R3: With `mode_single`=1 the tick period is 2·(S+1) cycles, where S is control bits [15:0]. Bits [31:17] have no effect in this mode.
- R4: With `mode_single`=0, control bits [16:10] have no effect on the period.
- R5: `adc_tick` is never high in two consecutive cycles.
- R6: `sample_strobe` is high only in a cycle where `adc_tick` is high, once every 12 ticks. Its period is 12 times the tick period.
- R7: A control write or strap change takes effect only after the next tick. The period running at the time of the write keeps its old length.
- R8: `reg_rdata` returns the last word written, updated in the cycle after `reg_wr_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_single | input | 1 | 1 selects the single 16-bit scaler, 0 selects prescaler plus 10-bit scaler |
| reg_wr_en | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Control word to write |
| reg_rdata | output | 32 | Current control word |
| adc_tick | output | 1 | One-cycle enable at the ADC clock rate |
| sample_strobe | output | 1 | One-cycle enable at the end of each 12-tick conversion |

## Verification
The bench measures tick periods for several control words in both modes, using fields that differ from each other. A design that swapped the prescaler and scaler positions, or kept the prescaler active in single-stage mode, would measure wrong on the vectors that fill the unused bits. It writes a short setting halfway through a long period. A design that reloaded at once would show a shortened interval. It also counts strobes against ticks. An off-by-one in the conversion counter would show up as an 11- or 13-tick frame.

// File: rtl/adc_clkdiv_pkg.sv
package adc_clkdiv_pkg;
  localparam int REG_W      = 32;
  localparam int PRE_W      = 15;
  localparam int PRE_LSB    = 17;
  localparam int LEG_SC_W   = 10;
  localparam int WIDE_SC_W  = 16;
  localparam int CONV_TICKS = 12;

  typedef struct packed {
    logic [PRE_W-1:0]     pre;
    logic [WIDE_SC_W-1:0] scl;
  } div_cfg_t;

  function automatic div_cfg_t decode_cfg(input logic [REG_W-1:0] word,
                                          input logic single);
    div_cfg_t c;
    if (single) begin
      c.pre = '0;
      c.scl = word[WIDE_SC_W-1:0];
    end else begin
      c.pre = word[PRE_LSB +: PRE_W];
      c.scl = {{(WIDE_SC_W-LEG_SC_W){1'b0}}, word[LEG_SC_W-1:0]};
    end
    return c;
  endfunction
endpackage

// File: rtl/clkdiv_count_stage.sv
module clkdiv_count_stage #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [W-1:0] limit_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == limit_i);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (tick_o)  cnt_q <= '0;
    else if (en_i)    cnt_q <= cnt_q + 1'b1;
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit_i); // R2
endmodule

// File: rtl/clkdiv_conv_strobe.sv
module clkdiv_conv_strobe #(
  parameter int N = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  output logic strobe_o
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);
  logic [CW-1:0] cnt_q;

  assign strobe_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt_q <= '0;
    else if (strobe_o)  cnt_q <= '0;
    else if (en_i)      cnt_q <= cnt_q + 1'b1;
  end

  AST_CONV_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R6
endmodule

// File: rtl/adc_sample_clkdiv.sv
module adc_sample_clkdiv
  import adc_clkdiv_pkg::*;
#(
  parameter int CONV_N = CONV_TICKS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_single,
  input  logic             reg_wr_en,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             adc_tick,
  output logic             sample_strobe
);
  logic [REG_W-1:0] ctrl_q;
  div_cfg_t         act_q;
  logic             half_tick;
  logic             pre_tick;

  always_ff @(posedge clk) begin
    if (!rst_n)         ctrl_q <= '0;
    else if (reg_wr_en) ctrl_q <= reg_wdata;
  end
  assign reg_rdata = ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        act_q <= '0;
    else if (adc_tick) act_q <= decode_cfg(ctrl_q, mode_single);
  end

  clkdiv_count_stage #(.W(1)) half_i (
    .clk(clk), .rst_n(rst_n), .en_i(1'b1), .limit_i(1'b1), .tick_o(half_tick));

  clkdiv_count_stage #(.W(PRE_W)) pre_i (
    .clk(clk), .rst_n(rst_n), .en_i(half_tick), .limit_i(act_q.pre), .tick_o(pre_tick));

  clkdiv_count_stage #(.W(WIDE_SC_W)) scl_i (
    .clk(clk), .rst_n(rst_n), .en_i(pre_tick), .limit_i(act_q.scl), .tick_o(adc_tick));

  clkdiv_conv_strobe #(.N(CONV_N)) conv_i (
    .clk(clk), .rst_n(rst_n), .en_i(adc_tick), .strobe_o(sample_strobe));

  AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    adc_tick |=> !adc_tick); // R5
  AST_STROBE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    sample_strobe |-> adc_tick); // R6
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(adc_tick) |-> $stable(act_q)); // R7
  AST_HALF_ALT: assert property (@(posedge clk) disable iff (!rst_n)
    half_tick |=> !half_tick); // R1
endmodule

// File: tb/adc_sample_clkdiv_tb_top.sv
module adc_sample_clkdiv_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        mode_single = 0;
  logic        reg_wr_en = 0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        adc_tick, sample_strobe;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  adc_sample_clkdiv dut_i (
    .clk(clk), .rst_n(rst_n), .mode_single(mode_single),
    .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .adc_tick(adc_tick), .sample_strobe(sample_strobe));

  localparam int NV = 8;
  localparam logic [31:0] V_WORD [NV] = '{
    32'h0000_0000, 32'h0002_0002, 32'h0004_0000, 32'h0001_FC01,
    32'h0000_0005, 32'hFFFE_0003, 32'h0006_0004, 32'h0000_03FF};
  localparam bit V_MODE [NV] = '{0, 0, 0, 0, 1, 1, 0, 1};
  localparam int V_PER [NV] = '{2, 12, 6, 4, 12, 8, 40, 2048};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_tick(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!adc_tick && n < 10000);
    if (!adc_tick) begin
      failures++;
      $display("FAIL watchdog: no tick within %0d cycles", n);
    end
  endtask

  task automatic write_cfg(input logic [31:0] w, input bit m);
    @(negedge clk);
    reg_wr_en = 1; reg_wdata = w; mode_single = m;
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  initial begin
    int n;
    int ticks;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check("R1 reset rdata", int'(reg_rdata), 0);
    wait_tick(n);
    wait_tick(n);
    check("R1 reset period", n, 2);

    for (int i = 0; i < NV; i++) begin
      write_cfg(V_WORD[i], V_MODE[i]);
      check("R8 readback", int'(reg_rdata), int'(V_WORD[i]));
      wait_tick(n);
      wait_tick(n);
      wait_tick(n);
      if (i == 3)          check("R4 bits 16:10 ignored", n, V_PER[i]);
      else if (V_MODE[i])  check("R3 single period", n, V_PER[i]);
      else                 check("R2 cascaded period", n, V_PER[i]);
    end

    // R7: write a short setting mid-way through a long period
    write_cfg(32'h0000_0063, 1'b1);
    wait_tick(n);
    wait_tick(n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 50) begin reg_wr_en = 1; reg_wdata = 32'h0; end
      else reg_wr_en = 0;
    end while (!adc_tick && n < 10000);
    reg_wr_en = 0;
    check("R7 period kept at write", n, 200);
    wait_tick(n);
    check("R7 new period after tick", n, 2);

    // R6: conversion strobe framing
    mode_single = 0;
    n = 0;
    do begin @(negedge clk); n++; end while (!sample_strobe && n < 10000);
    n = 0; ticks = 0;
    do begin
      @(negedge clk);
      n++;
      if (adc_tick) ticks++;
    end while (!sample_strobe && n < 10000);
    check("R6 strobe period", n, 24);
    check("R6 ticks per strobe", ticks, 12);
    check("R6 strobe with tick", int'(adc_tick), 1);

    // R5: tick never high two cycles running
    n = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (adc_tick) begin
        @(negedge clk);
        c++;
        if (adc_tick) n++;
      end
    end
    check("R5 single-cycle tick", n, 0);

    // R1: reset mid-run restores defaults
    write_cfg(32'h0006_0004, 1'b0);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    #1;
    check("R1 rdata after reset", int'(reg_rdata), 0);
    wait_tick(n);
    wait_tick(n);
    check("R1 period after reset", n, 2);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule